// File: doc/BRIEF.md
# Internal-Feedback Pseudo-Random Pattern Generator

This block is an 8-bit shift register with internal (Galois-style) exclusive-or feedback. It produces one pseudo-random test pattern per enabled clock. The register moves its contents down toward bit 0. The bit leaving at the bottom is copied into the top stage, and it is also XORed into every intermediate stage that a fixed 7-bit tap coefficient vector selects.

A client loads a starting value (the seed) through a synchronous load port, then raises the step enable to advance one pattern per cycle. A one-cycle wrap flag marks the step that brings the register back to the active seed, so a consumer can delimit or count the period. Two operand streams can be drawn by seeding two instances, or one instance at two times, with different values, for example 8'h01 and 8'h91. An all-zero seed would lock the register at zero, so the block replaces it with 8'h01.

Top module: `galois_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes 8'h01 and the active seed becomes 8'h01. `wrap_o` is 0 in the cycle that follows.
- R2: On a step, the new bit 7 equals the old bit 0. For j from 1 to 7, the new bit j-1 equals old bit j XOR (C_j AND old bit 0).
- R3: The tap coefficients are fixed at C7..C1 = 7'b1001111, held in parameter bits TAPS[6:0], where TAPS[j-1] is C_j.
- R4: When `load_i` is high at an edge, the state and the active seed both take the value on `seed_i`. A load overrides `step_i` in the same cycle.
- R5: A load of 8'h00 sets both the state and the active seed to 8'h01. The state is never zero after reset.
- R6: With `load_i` and `step_i` both low, the state keeps its value and `wrap_o` is 0.
- R7: `wrap_o` is high for exactly the one cycle after a step whose new state equals the active seed. A load never raises it, even when the loaded value equals the previous seed.
- R8: Starting from a seed and stepping, the state comes back to that seed. The number of steps until the first wrap equals the period of the R2 recurrence, for seed 8'h01 and for seed 8'h91.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load `seed_i` as the new state and the new active seed |
| seed_i | input | 8 | Seed value used by a load |
| step_i | input | 1 | Advance the register by one shift |
| state_o | output | 8 | Current register state (the pattern) |
| wrap_o | output | 1 | One-cycle pulse when a step returns the register to the seed |

## Verification
The bench builds the block with its default parameters: WIDTH of 8, TAPS of 7'b1001111 and a fallback seed of 8'h01. Because the width is 8, a full cycle of the register is at most 255 steps. Full periods from seeds 8'h01 and 8'h91 can therefore be walked in a few hundred cycles, and every state in them is compared against an independent model of the recurrence. The small width also puts the zero-seed substitution, the case where a load and a step arrive together, and a reload of the same seed (with no wrap expected) within a short directed sequence.

// File: rtl/galois_pat_pkg.sv
// Package: galois_pat_pkg
// Shared types for the internal-feedback pattern generator.
// Assumes: consumers import it before declaring ports that use its types.
package galois_pat_pkg;

    // Action the state register performs at the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } gen_action_e;

endpackage

// File: rtl/galois_tap_network.sv
// Module: galois_tap_network
// Combinational next-state network for a right-shifting register with
// internal feedback. Bit 0 feeds the top stage. Each lower stage takes
// the stage above it, XORed with bit 0 where the tap bit is set.
// Assumes: TAPS[j-1] is the coefficient for the stage j -> j-1 path.
module galois_tap_network #(
    parameter int unsigned         WIDTH = 8,
    parameter logic [WIDTH-2:0]    TAPS  = 7'b1001111
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);

    logic fb;

    // Purpose: the feedback bit leaves the register at the bottom.
    assign fb = cur_i[0];

    // Purpose: the top stage closes the loop with the feedback bit.
    assign nxt_o[WIDTH-1] = fb;

    // Purpose: each lower stage, with or without a feedback XOR.
    for (genvar j = 1; j < WIDTH; j++) begin : g_stage
        if (TAPS[j-1]) begin : g_tap
            assign nxt_o[j-1] = cur_i[j] ^ fb;
        end else begin : g_pass
            assign nxt_o[j-1] = cur_i[j];
        end
    end

endmodule

// File: rtl/galois_seed_guard.sv
// Module: galois_seed_guard
// Replaces an all-zero seed, which would lock the register, with a
// fixed nonzero fallback value.
// Assumes: FALLBACK is nonzero.
module galois_seed_guard #(
    parameter int unsigned      WIDTH    = 8,
    parameter logic [WIDTH-1:0] FALLBACK = 8'h01
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] safe_o
);

    logic is_zero;

    // Purpose: detect the lock-up seed.
    assign is_zero = (raw_i == '0);

    // Purpose: substitute the fallback for the lock-up seed.
    assign safe_o = is_zero ? FALLBACK : raw_i;

endmodule

// File: rtl/galois_state_reg.sv
// Module: galois_state_reg
// Holds the pattern state, the active seed and the wrap pulse.
// Assumes: load_val_i is already nonzero. rst_n is synchronous, active low.
module galois_state_reg
    import galois_pat_pkg::*;
#(
    parameter int unsigned      WIDTH     = 8,
    parameter logic [WIDTH-1:0] RST_VALUE = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gen_action_e      action_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic [WIDTH-1:0] next_val_i,
    output logic [WIDTH-1:0] state_q,
    output logic [WIDTH-1:0] seed_q,
    output logic             wrap_q
);

    // Purpose: update the state according to the action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_VALUE;
        end else begin
            case (action_i)
                ACT_LOAD: state_q <= load_val_i;
                ACT_STEP: state_q <= next_val_i;
                default:  state_q <= state_q;
            endcase
        end
    end

    // Purpose: remember the seed that defines the wrap point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= RST_VALUE;
        end else if (action_i == ACT_LOAD) begin
            seed_q <= load_val_i;
        end
    end

    // Purpose: pulse when a step lands on the active seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= (action_i == ACT_STEP) && (next_val_i == seed_q);
        end
    end

    // R6: holding keeps the state unchanged.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (action_i == ACT_HOLD) |=> (state_q == $past(state_q)));

    // R4: a load shows up as the state on the next cycle.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (action_i == ACT_LOAD) |=> (state_q == $past(load_val_i)) && !wrap_q);

    // R2: after a step the top bit carries the old bottom bit.
    p_top_fb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (action_i == ACT_STEP) |=> (state_q[WIDTH-1] == $past(state_q[0])));

    // R7: a wrap pulse only ever marks the active seed.
    p_wrap_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (state_q == seed_q));

endmodule

// File: rtl/galois_pattern_gen.sv
// Module: galois_pattern_gen
// Top of the internal-feedback pattern generator. Decodes the load and
// step controls (load wins), guards the seed against zero, and ties the
// tap network to the state register.
// Assumes: synchronous active-low reset. FALLBACK_SEED is nonzero.
module galois_pattern_gen
    import galois_pat_pkg::*;
#(
    parameter int unsigned      WIDTH         = 8,
    parameter logic [WIDTH-2:0] TAPS          = 7'b1001111,
    parameter logic [WIDTH-1:0] FALLBACK_SEED = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] state_o,
    output logic             wrap_o
);

    gen_action_e      action;
    logic [WIDTH-1:0] safe_seed;
    logic [WIDTH-1:0] next_state;
    logic [WIDTH-1:0] cur_state;
    logic [WIDTH-1:0] active_seed;
    logic             wrap_pulse;

    // Purpose: decode the controls, with load taking priority.
    always_comb begin
        if (load_i)      action = ACT_LOAD;
        else if (step_i) action = ACT_STEP;
        else             action = ACT_HOLD;
    end

    galois_seed_guard #(
        .WIDTH    (WIDTH),
        .FALLBACK (FALLBACK_SEED)
    ) u_guard (
        .raw_i  (seed_i),
        .safe_o (safe_seed)
    );

    galois_tap_network #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) u_taps (
        .cur_i (cur_state),
        .nxt_o (next_state)
    );

    galois_state_reg #(
        .WIDTH     (WIDTH),
        .RST_VALUE (FALLBACK_SEED)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .action_i   (action),
        .load_val_i (safe_seed),
        .next_val_i (next_state),
        .state_q    (cur_state),
        .seed_q     (active_seed),
        .wrap_q     (wrap_pulse)
    );

    // Purpose: drive the outputs.
    assign state_o = cur_state;
    assign wrap_o  = wrap_pulse;

    // R5: the state never reaches the lock-up value.
    p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != '0));

    // R4: a load overrides a step raised in the same cycle.
    p_load_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && step_i) |=> (state_o == active_seed) && !wrap_o);

endmodule

// File: tb/galois_pattern_gen_tb_top.sv
module galois_pattern_gen_tb_top;

    localparam logic [6:0] TB_TAPS = 7'b1001111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] seed_i = 8'h00;
    logic       step_i = 1'b0;
    logic [7:0] state_o;
    logic       wrap_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_state;
    logic [7:0] m_seed;
    logic       m_wrap;

    always #10 clk = ~clk;  // 50 MHz

    galois_pattern_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .seed_i  (seed_i),
        .step_i  (step_i),
        .state_o (state_o),
        .wrap_o  (wrap_o)
    );

    // Model of the R2/R3 recurrence.
    function automatic logic [7:0] ref_next(input logic [7:0] y);
        logic [7:0] n;
        n[7] = y[0];
        for (int j = 1; j < 8; j++) n[j-1] = y[j] ^ (TB_TAPS[j-1] & y[0]);
        return n;
    endfunction

    function automatic int ref_period(input logic [7:0] s);
        logic [7:0] y = s;
        int n = 0;
        do begin
            y = ref_next(y);
            n++;
        end while (y != s && n < 300);
        return n;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, update the model, compare at the falling edge.
    task automatic cycle(input logic ld, input logic [7:0] sd, input logic st, input string req);
        load_i = ld; seed_i = sd; step_i = st;
        @(posedge clk);
        if (ld) begin
            m_seed  = (sd == 8'h00) ? 8'h01 : sd;
            m_state = m_seed;
            m_wrap  = 1'b0;
        end else if (st) begin
            m_state = ref_next(m_state);
            m_wrap  = (m_state == m_seed);
        end else begin
            m_wrap = 1'b0;
        end
        @(negedge clk);
        check(req, state_o, m_state);
        check(req, {7'b0, wrap_o}, {7'b0, m_wrap});
    endtask

    // Vector table: {load, step, seed}
    localparam logic [9:0] VEC [0:11] = '{
        {1'b0, 1'b1, 8'h00}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00}, {1'b1, 1'b0, 8'h91}, {1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 8'h00}, {1'b1, 1'b1, 8'h5A}, {1'b0, 1'b1, 8'h00},
        {1'b1, 1'b0, 8'h00}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'hFF}
    };

    task automatic walk_period(input logic [7:0] sd, input string req);
        int exp_p = ref_period(sd);
        int got_p = 0;
        cycle(1'b1, sd, 1'b0, req);
        while (got_p < 300) begin
            cycle(1'b0, 8'h00, 1'b1, req);
            got_p++;
            if (wrap_o) break;
        end
        check(req, got_p[7:0], exp_p[7:0]);
        check(req, state_o, sd);
        $display("seed %h period %0d", sd, got_p);
    endtask

    initial begin
        m_state = 8'h01; m_seed = 8'h01; m_wrap = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", state_o, 8'h01);
        check("R1 reset wrap", {7'b0, wrap_o}, 8'h00);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 mixed patterns
        for (int i = 0; i < 12; i++)
            cycle(VEC[i][9], VEC[i][7:0], VEC[i][8], "R2/R4/R6 table");

        // R3: one step from 8'h01 applies all taps: expect 8'hCF
        cycle(1'b1, 8'h01, 1'b0, "R4 load");
        cycle(1'b0, 8'h00, 1'b1, "R3 tap vector");
        check("R3 tap value", state_o, 8'hCF);

        // R5: zero seed forced to 8'h01
        cycle(1'b1, 8'h00, 1'b0, "R5 zero seed");
        check("R5 zero seed value", state_o, 8'h01);

        // R6: hold for several cycles
        cycle(1'b0, 8'h00, 1'b1, "R6 pre-step");
        for (int i = 0; i < 4; i++) cycle(1'b0, 8'hAA, 1'b0, "R6 hold");

        // R7: reloading the same seed gives no wrap
        cycle(1'b1, 8'h37, 1'b0, "R7 load");
        cycle(1'b1, 8'h37, 1'b0, "R7 reload no wrap");
        check("R7 reload wrap", {7'b0, wrap_o}, 8'h00);

        // R8: full periods from both seeds, wrap one cycle wide
        walk_period(8'h01, "R8 seed 01");
        cycle(1'b0, 8'h00, 1'b1, "R7 pulse ends");
        walk_period(8'h91, "R8 seed 91");
        cycle(1'b0, 8'h00, 1'b0, "R7 pulse ends on hold");

        // R1: reset mid-run
        rst_n = 1'b0;
        step_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", state_o, 8'h01);
        rst_n = 1'b1;
        m_state = 8'h01; m_seed = 8'h01;
        cycle(1'b0, 8'h00, 1'b1, "R1 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule